// File: doc/BRIEF.md
# Multi-Channel PWM Register Bank

This block is a bank of independent pulse-width modulators behind a small memory-mapped register port. The channel count is a build parameter (2, 4 or 8). Each channel has a 32-bit period and a 32-bit high-time, both counted in cycles of the block clock. A spare configuration word is stored and read back but has no effect on the output. A control word holds a run bit, an output-invert bit and a repeat bit. Each channel drives one output pin.

Software writes period and high-time into holding (shadow) registers. These values reach the live counter only when the run bit is written as 1. That write also restarts the period from count zero, whether or not the channel was already running. With the repeat bit set, a channel produces periods without end. With the repeat bit clear, it produces exactly one period, then clears its own run bit and idles. Reads are combinational: `rd_data` follows `addr` in the same cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register of every channel reads 0 and every pin is low.
- R2: Channel n owns byte addresses n*0x20 to n*0x20+0x1F. Word +0x0 is the period shadow, +0x4 the high-time shadow, +0x8 the spare word, and +0xC the control word. Control bit 0 is run, bit 1 is invert and bit 2 is repeat. Each of the four words reads back the last value written to it, and reads of control show the current run state.
- R3: The running waveform is set by the active values. In the k-th cycle after the run bit is written as 1, the counter equals k mod period, and the uninverted output is high exactly while counter < high-time.
- R4: When the invert bit is 1, the pin carries the complement of the uninverted output, both while running and while idle.
- R5: Writing the period or high-time shadow leaves the live waveform unchanged. Writing control with bit 0 = 1 copies both shadows into the live counter and restarts the period at count 0, even when the channel is already running.
- R6: A high-time greater than or equal to the period gives a constant active level. A high-time of 0 gives a constant inactive level. A period of 0 keeps the pin at the inactive level.
- R7: With repeat = 0, the channel stays active for exactly one period after the run write. It then returns to the inactive level, and its control word reads run = 0.
- R8: Writing control with bit 0 = 0 drives the inactive level (the invert bit's value) from the very next cycle.
- R9: Channels run independently. Traffic to one channel never changes another channel's pin or registers.
- R10: Addresses whose low two bits are non-zero, offsets +0x10 to +0x1F, and windows at or above the channel count all read 0. Writes to any of these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the counters count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register being read or written |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench targets the restart edge cases. These are a run write to a channel that is already running, which must adopt the shadow values and begin again at phase zero, and shadow writes alone, which must not disturb a running waveform. A design that loaded shadows at once would show a different high count over a fixed window. A design that did not restart the phase would break the cycle-exact scoreboard. The bench also covers degenerate settings: zero period, zero high-time, a high-time at or above the period, and single-shot mode. A wrong compare or a missing self-clear shows up there as a stray pulse or a pin stuck active. Out-of-range and misaligned writes that alias onto channel 0 are caught by readback and by watching the pins stay at idle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int REG_W        = 32;
    localparam int WIN_BITS     = 5;   // 0x20-byte window per channel
    localparam int CTRL_RUN     = 0;
    localparam int CTRL_INVERT  = 1;
    localparam int CTRL_REPEAT  = 2;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_HIGH   = 2'd1,
        SEL_SPARE  = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] period_sh;
        logic [REG_W-1:0] high_sh;
        logic [REG_W-1:0] spare;
        logic [REG_W-1:0] period_act;
        logic [REG_W-1:0] high_act;
        logic [REG_W-1:0] cnt;
        logic             run;
        logic             invert;
        logic             repeat_en;
    } chan_state_t;

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              hit,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] ch_idx,
    output reg_sel_e          sel,
    output logic [NUM_CH-1:0] wr_stb
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [31:0] addr_ext;
    logic        inner_ok;
    logic        range_ok;

    assign addr_ext = 32'(addr);
    assign inner_ok = (addr[1:0] == 2'b00) && (addr[4] == 1'b0);
    assign range_ok = (addr_ext >> WIN_BITS) < 32'(NUM_CH);
    assign hit      = inner_ok && range_ok;
    assign ch_idx   = addr[WIN_BITS +: CH_W];
    assign sel      = reg_sel_e'(addr[3:2]);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            wr_stb[i] = wr_en && hit && (ch_idx == CH_W'(i));
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_word,
    output logic             pin
);

    chan_state_t s_d, s_q;
    logic        wrap;
    logic        active;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.period_act == '0) || (s_q.cnt == s_q.period_act - 32'd1);

        if (s_q.run) begin
            if (wrap) begin
                s_d.cnt = '0;
                if (!s_q.repeat_en) begin
                    s_d.run = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt + 32'd1;
            end
        end

        if (wr_stb) begin
            unique case (sel)
                SEL_PERIOD: s_d.period_sh = wdata;
                SEL_HIGH:   s_d.high_sh   = wdata;
                SEL_SPARE:  s_d.spare     = wdata;
                SEL_CTRL: begin
                    s_d.run       = wdata[CTRL_RUN];
                    s_d.invert    = wdata[CTRL_INVERT];
                    s_d.repeat_en = wdata[CTRL_REPEAT];
                    s_d.cnt       = '0;
                    if (wdata[CTRL_RUN]) begin
                        s_d.period_act = s_q.period_sh;
                        s_d.high_act   = s_q.high_sh;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.run && (s_q.period_act != '0) && (s_q.cnt < s_q.high_act);
    assign pin    = active ^ s_q.invert;

    always_comb begin
        unique case (sel)
            SEL_PERIOD: rd_word = s_q.period_sh;
            SEL_HIGH:   rd_word = s_q.high_sh;
            SEL_SPARE:  rd_word = s_q.spare;
            SEL_CTRL:   rd_word = {29'd0, s_q.repeat_en, s_q.invert, s_q.run};
            default:    rd_word = '0;
        endcase
    end

    // R3: counter never leaves the active period
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.period_act != '0) |-> (s_q.cnt < s_q.period_act));

    // R8: idle channel holds count zero and the inactive level
    a_r8_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> (s_q.cnt == '0 && pin == s_q.invert));

    // R7: single-shot channel stops after its last count
    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !s_q.repeat_en && wrap && !wr_stb) |=> !s_q.run);

    // R5: a run write loads the shadow values
    a_r5_reload_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_CTRL && wdata[CTRL_RUN]) |=>
        (s_q.period_act == $past(s_q.period_sh) && s_q.high_act == $past(s_q.high_sh)));

    // R5: without a control write the live values stay put
    a_r5_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && sel == SEL_CTRL) |=> ($stable(s_q.period_act) && $stable(s_q.high_act)));

    // R6: high-time at or above the period keeps the pin active
    a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.period_act != '0 && s_q.high_act >= s_q.period_act) |-> (pin != s_q.invert));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              hit;
    logic [CH_W-1:0]   ch_idx;
    reg_sel_e          sel;
    logic [NUM_CH-1:0] wr_stb;
    logic [REG_W-1:0]  ch_rd [NUM_CH];

    pwm_addr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .hit    (hit),
        .ch_idx (ch_idx),
        .sel    (sel),
        .wr_stb (wr_stb)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb[g]),
            .sel     (sel),
            .wdata   (wr_data),
            .rd_word (ch_rd[g]),
            .pin     (pwm_out[g])
        );
    end

    assign rd_data = hit ? ch_rd[ch_idx] : '0;

    // R9: a write reaches at most one channel
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    // R10: an unmapped address produces no write strobe
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (wr_stb == '0));

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

    localparam int NCH = 4;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic           wr_en = 1'b0;
    logic [31:0]    wr_data = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pwm_out;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) i_pwm_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] exp;
        string          tag;
    } item_t;

    item_t sb[$];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int per, input int high, input bit inv,
                                     input bit rpt, input int i);
        bit act;
        if (per == 0 || (!rpt && i >= per)) act = 1'b0;
        else act = ((i % per) < high);
        return act ^ inv;
    endfunction

    task automatic push_run(input int ch, input int per, input int high, input bit inv,
                            input bit rpt, input int n, input string tag);
        item_t it;
        for (int i = 0; i < n; i++) begin
            it.mask = '0;
            it.exp  = '0;
            it.mask[ch] = 1'b1;
            it.exp[ch]  = exp_bit(per, high, inv, rpt, i);
            it.tag  = tag;
            sb.push_back(it);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic read_check(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    // scoreboard monitor: one expected item per cycle, sampled after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(((pwm_out ^ it.exp) & it.mask) == '0, it.tag,
                      32'(pwm_out & it.mask), 32'(it.exp & it.mask));
            end
        end
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        item_t it;
        int highs;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check(pwm_out == '0, "R1 pins", 32'(pwm_out), 32'd0);
        read_check(8'h00, 32'd0, "R1 period");
        read_check(8'h04, 32'd0, "R1 high");
        read_check(8'h08, 32'd0, "R1 spare");
        read_check(8'h0C, 32'd0, "R1 ctrl");
        read_check(8'h6C, 32'd0, "R1 ctrl ch3");

        // R2: register window layout and readback
        bus_write(8'h20, 32'h1234_5678);
        bus_write(8'h24, 32'h0000_00AB);
        bus_write(8'h28, 32'hCAFE_0001);
        bus_write(8'h2C, 32'h0000_0006);
        read_check(8'h20, 32'h1234_5678, "R2 period");
        read_check(8'h24, 32'h0000_00AB, "R2 high");
        read_check(8'h28, 32'hCAFE_0001, "R2 spare");
        read_check(8'h2C, 32'h0000_0006, "R2 ctrl");
        // R4: idle inverted channel sits high
        check(pwm_out[1] == 1'b1, "R4 idle invert", 32'(pwm_out[1]), 32'd1);
        bus_write(8'h2C, 32'h0);

        // R3: basic repeating waveform
        bus_write(8'h00, 32'd5);
        bus_write(8'h04, 32'd2);
        bus_write(8'h0C, 32'h5);
        push_run(0, 5, 2, 1'b0, 1'b1, 12, "R3");
        drain();

        // R5: shadow writes do not disturb the running waveform
        bus_write(8'h00, 32'd8);
        bus_write(8'h04, 32'd6);
        read_check(8'h00, 32'd8, "R5 shadow period");
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            #3;
            highs += int'(pwm_out[0]);
        end
        check(highs == 4, "R5 old waveform kept", 32'(highs), 32'd4);
        bus_write(8'h0C, 32'h5);
        push_run(0, 8, 6, 1'b0, 1'b1, 16, "R5 reload");
        drain();

        // R4: inverted running waveform
        bus_write(8'h0C, 32'h7);
        push_run(0, 8, 6, 1'b1, 1'b1, 8, "R4");
        drain();

        // R8: disable goes inactive next cycle
        bus_write(8'h0C, 32'h2);
        push_run(0, 0, 0, 1'b1, 1'b1, 5, "R8");
        drain();
        read_check(8'h0C, 32'h2, "R8 ctrl");

        // R6: degenerate settings
        bus_write(8'h00, 32'd4);
        bus_write(8'h04, 32'd4);
        bus_write(8'h0C, 32'h5);
        push_run(0, 4, 4, 1'b0, 1'b1, 8, "R6 high=period");
        drain();
        bus_write(8'h04, 32'd9);
        bus_write(8'h0C, 32'h5);
        push_run(0, 4, 9, 1'b0, 1'b1, 8, "R6 high>period");
        drain();
        bus_write(8'h04, 32'd0);
        bus_write(8'h0C, 32'h5);
        push_run(0, 4, 0, 1'b0, 1'b1, 8, "R6 high=0");
        drain();
        bus_write(8'h00, 32'd0);
        bus_write(8'h04, 32'd3);
        bus_write(8'h0C, 32'h5);
        push_run(0, 0, 3, 1'b0, 1'b1, 8, "R6 period=0");
        drain();

        // R7: single shot
        bus_write(8'h00, 32'd4);
        bus_write(8'h04, 32'd1);
        bus_write(8'h0C, 32'h1);
        push_run(0, 4, 1, 1'b0, 1'b0, 10, "R7");
        drain();
        read_check(8'h0C, 32'h0, "R7 run cleared");
        bus_write(8'h00, 32'd3);
        bus_write(8'h04, 32'd2);
        bus_write(8'h0C, 32'h3);
        push_run(0, 3, 2, 1'b1, 1'b0, 7, "R7 inverted");
        drain();
        read_check(8'h0C, 32'h2, "R7 run cleared inverted");

        // R9: two channels at once, others idle
        bus_write(8'h40, 32'd3);
        bus_write(8'h44, 32'd1);
        bus_write(8'h60, 32'd5);
        bus_write(8'h64, 32'd3);
        bus_write(8'h4C, 32'h5);
        bus_write(8'h6C, 32'h7);
        for (int i = 0; i < 15; i++) begin
            it.mask = 4'b1111;
            it.exp  = {exp_bit(5, 3, 1'b1, 1'b1, i), exp_bit(3, 1, 1'b0, 1'b1, i + 1), 1'b0, 1'b1};
            it.tag  = "R9";
            sb.push_back(it);
        end
        drain();
        read_check(8'h00, 32'd3, "R9 ch0 period untouched");
        bus_write(8'h4C, 32'h0);
        bus_write(8'h6C, 32'h0);

        // R10: unmapped addresses
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_write(8'h8C, 32'h5);
        bus_write(8'h10, 32'h77);
        bus_write(8'h01, 32'h99);
        read_check(8'h00, 32'd3, "R10 ch0 period");
        read_check(8'h04, 32'd2, "R10 ch0 high");
        read_check(8'h0C, 32'h2, "R10 ch0 ctrl");
        read_check(8'h10, 32'h0, "R10 inner gap");
        read_check(8'h80, 32'h0, "R10 out of range");
        read_check(8'h01, 32'h0, "R10 misaligned");
        for (int i = 0; i < 6; i++) begin
            it.mask = 4'b1111;
            it.exp  = 4'b0001;
            it.tag  = "R10 pins idle";
            sb.push_back(it);
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule